// File: doc/BRIEF.md
# Flagged Four-Operation Integer ALU

This block is a purely combinational 32-bit integer unit. It takes two signed two's-complement operands and a 2-bit operation select. It returns a 32-bit two's-complement result together with three status flags: overflow, negative and zero. The operations are addition, subtraction, bitwise XOR and bitwise AND. Operands and result stay in two's-complement form throughout, and no conversion step is applied on the way in or out.

Both arithmetic operations share one binary adder. Subtraction feeds the adder the inverted second operand and a carry-in of one. Any carry beyond the top bit is dropped, so results wrap modulo 2^32. Overflow is worked out from the sign bits of the operands and the result, and it is reported only for the arithmetic operations. The negative and zero flags always describe whatever result is selected. A surrounding pipeline registers the outputs where it needs to.

Top module: `flagged_alu`

## Requirements
- R1: With op_sel = 2'b00 the result is opnd_a + opnd_b, keeping only the low 32 bits (wraps modulo 2^32).
- R2: With op_sel = 2'b01 the result is opnd_a - opnd_b, keeping only the low 32 bits.
- R3: With op_sel = 2'b10 the result is the bitwise XOR of opnd_a and opnd_b.
- R4: With op_sel = 2'b11 the result is the bitwise AND of opnd_a and opnd_b.
- R5: For addition, ovf is 1 exactly when both operands have bit 31 equal and result bit 31 differs from it. This is the case where the true sum lies outside [-2^31, 2^31-1].
- R6: For subtraction, ovf is 1 exactly when the operands' bit 31 differ and result bit 31 differs from bit 31 of opnd_a. This is the case where the true difference lies outside the signed 32-bit range.
- R7: For op_sel = 2'b10 and 2'b11, ovf is 0 whatever the operands are.
- R8: For every op_sel, neg equals bit 31 of result.
- R9: For every op_sel, zero is 1 exactly when all 32 result bits are 0.
- R10: All outputs are combinational functions of the current inputs, with no clock, no stored state and no latch. Every op_sel value drives all four outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First signed operand (two's complement) |
| opnd_b | input | 32 | Second signed operand (two's complement) |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 XOR, 11 AND |
| result | output | 32 | Operation result (two's complement) |
| ovf | output | 1 | Signed overflow of add/subtract; 0 for logical ops |
| neg | output | 1 | Result bit 31 |
| zero | output | 1 | Result is all zeros |

## Verification
The vector table exercises each operation on several operand classes, and each class separates a different possible fault:
- Negative-plus-negative pairs show that the carry out is discarded rather than taken as overflow.
- The pair -1 plus 1 wraps to zero, which exposes a broken zero flag.
- Mixed-sign operands must never overflow.
- Pairs at the extremes of the range (0x7FFFFFFF, 0x80000000) must overflow in both directions.
- Logical cases run with the same operands that overflow under arithmetic. This shows that overflow is masked by the opcode and not by the data.
- Results with bit 31 set separate the negative flag from a nonzero test.

A pseudo-random sweep is then checked against a widened-precision reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_XOR = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             sgn_ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin_vec;

  // Subtraction: a + ~b + 1
  assign b_eff   = do_sub ? ~in_b : in_b;
  assign cin_vec = {{(WIDTH-1){1'b0}}, do_sub};
  assign sum     = in_a + b_eff + cin_vec;

  // Like-signed adder inputs giving an opposite-signed sum
  assign sgn_ovf = (in_a[MSB] == b_eff[MSB]) && (sum[MSB] != in_a[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             pick_and,
  output logic [WIDTH-1:0] out_y
);
  assign out_y = pick_and ? (in_a & in_b) : (in_a ^ in_b);
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic             is_arith,
  input  logic             raw_ovf,
  output logic             f_ovf,
  output logic             f_neg,
  output logic             f_zero
);
  assign f_ovf  = is_arith & raw_ovf;
  assign f_neg  = res[WIDTH-1];
  assign f_zero = ~|res;
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             neg,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] logic_y;
  logic             arith_ovf;
  logic             is_arith;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .in_a    (opnd_a),
    .in_b    (opnd_b),
    .do_sub  (op == OP_SUB),
    .sum     (arith_y),
    .sgn_ovf (arith_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .in_a     (opnd_a),
    .in_b     (opnd_b),
    .pick_and (op == OP_AND),
    .out_y    (logic_y)
  );

  // R10: full case with default, no latch
  always_comb begin
    case (op)
      OP_ADD, OP_SUB: result = arith_y;
      default:        result = logic_y;
    endcase
  end

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res      (result),
    .is_arith (is_arith),
    .raw_ovf  (arith_ovf),
    .f_ovf    (ovf),
    .f_neg    (neg),
    .f_zero   (zero)
  );

  always_comb begin
    // R7: logical ops never overflow
    a_r7_logic_no_ovf: assert (!(op_sel[1] && ovf));
    // R5: mixed-sign addition cannot overflow
    a_r5_mixed_add_no_ovf: assert (!(op_sel == 2'b00 && opnd_a[MSB] != opnd_b[MSB] && ovf));
    // R6: like-signed subtraction cannot overflow
    a_r6_like_sub_no_ovf: assert (!(op_sel == 2'b01 && opnd_a[MSB] == opnd_b[MSB] && ovf));
    // R3: XOR result is zero only when the operands match
    a_r3_xor_zero_iff_equal: assert (op_sel != 2'b10 || zero == (opnd_a == opnd_b));
    // R4: AND result is negative only if both operands are negative
    a_r4_and_neg: assert (op_sel != 2'b11 || neg == (opnd_a[MSB] & opnd_b[MSB]));
    // R6: subtracting a value from itself gives zero, no overflow
    a_r6_self_sub_zero: assert (!(op_sel == 2'b01 && opnd_a == opnd_b) || (zero && !ovf));
  end
endmodule

// File: tb/flagged_alu_tb.sv
module flagged_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // {op[2], a[32], b[32], r[32], v, n, z}
  localparam logic [100:0] VEC [NVEC] = '{
    {2'b00, 32'hFFFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFEF, 3'b010},
    {2'b00, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b001},
    {2'b00, 32'hFFFFFFFC, 32'hFFFFFFFC, 32'hFFFFFFF8, 3'b010},
    {2'b00, 32'h98998998, 32'h12341234, 32'hAACD9BCC, 3'b010},
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b110},
    {2'b00, 32'h80000000, 32'h80000000, 32'h00000000, 3'b101},
    {2'b00, 32'h00000025, 32'h00080808, 32'h0008082D, 3'b000},
    {2'b01, 32'hFFFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFF1, 3'b010},
    {2'b01, 32'h98998998, 32'h12341234, 32'h86657764, 3'b010},
    {2'b01, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 3'b100},
    {2'b01, 32'h00000000, 32'h80000000, 32'h80000000, 3'b110},
    {2'b01, 32'h12345678, 32'h12345678, 32'h00000000, 3'b001},
    {2'b10, 32'hF0F0F0F0, 32'hCFCFCFCF, 32'h3F3F3F3F, 3'b000},
    {2'b10, 32'h00000000, 32'h11111111, 32'h11111111, 3'b000},
    {2'b10, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 3'b010},
    {2'b10, 32'h80000000, 32'h80000000, 32'h00000000, 3'b001},
    {2'b11, 32'hF0F0F0F0, 32'hCFCFCFCF, 32'hC0C0C0C0, 3'b010},
    {2'b11, 32'h00000000, 32'h11111111, 32'h00000000, 3'b001},
    {2'b11, 32'h7FFFFFFF, 32'h00000001, 32'h00000001, 3'b000},
    {2'b11, 32'hFFFFFFFF, 32'h0A0AB0B0, 32'h0A0AB0B0, 3'b000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  op_sel = '0;
  logic [31:0] result;
  logic        ovf, neg, zero;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagged_alu u_dut (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .result (result),
    .ovf    (ovf),
    .neg    (neg),
    .zero   (zero)
  );

  task automatic check(input string req, input logic [31:0] er,
                       input logic ev, input logic en, input logic ez);
    n_checks++;
    if (result !== er || ovf !== ev || neg !== en || zero !== ez) begin
      n_errors++;
      $display("FAIL %s: op=%b a=%h b=%h got r=%h v%b n%b z%b exp r=%h v%b n%b z%b",
               req, op_sel, opnd_a, opnd_b, result, ovf, neg, zero, er, ev, en, ez);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = o; opnd_a = a; opnd_b = b;
    #1;
  endtask

  // Reference model: widened signed arithmetic
  task automatic ref_model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] r, output logic v);
    logic signed [33:0] wide;
    case (o)
      2'b00: wide = $signed({{2{a[31]}}, a}) + $signed({{2{b[31]}}, b});
      2'b01: wide = $signed({{2{a[31]}}, a}) - $signed({{2{b[31]}}, b});
      2'b10: wide = {2'b00, a ^ b};
      default: wide = {2'b00, a & b};
    endcase
    r = wide[31:0];
    v = (o[1] == 1'b0) && (wide > 34'sh07FFFFFFF || wide < -34'sh080000000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: R10 run did not complete, got hang, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr_a, lfsr_b, er;
    logic        ev;
    string       tag;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Idle state: zero inputs, add -> zero result (R9, R10)
    apply(2'b00, 32'h0, 32'h0);
    check("R9 idle", 32'h0, 1'b0, 1'b0, 1'b1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][100:99], VEC[i][98:67], VEC[i][66:35]);
      case (VEC[i][100:99])
        2'b00: tag = "R1/R5/R8/R9 add";
        2'b01: tag = "R2/R6/R8/R9 sub";
        2'b10: tag = "R3/R7/R8/R9 xor";
        default: tag = "R4/R7/R8/R9 and";
      endcase
      check(tag, VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R7: overflowing operands under logical ops
    apply(2'b10, 32'h7FFFFFFF, 32'h00000001);
    check("R7 xor no ovf", 32'h7FFFFFFE, 1'b0, 1'b0, 1'b0);
    apply(2'b11, 32'h80000000, 32'h80000000);
    check("R7 and no ovf", 32'h80000000, 1'b0, 1'b1, 1'b0);

    // R10: output follows input change without a clock edge
    op_sel = 2'b00; opnd_a = 32'h1; opnd_b = 32'h2;
    #1;
    check("R10 comb follow", 32'h3, 1'b0, 1'b0, 1'b0);

    // Pseudo-random sweep across all ops
    lfsr_a = 32'hACE1_2468;
    lfsr_b = 32'h1357_BDF0;
    for (int k = 0; k < 400; k++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      apply(2'(k), lfsr_a, lfsr_b);
      ref_model(2'(k), lfsr_a, lfsr_b, er, ev);
      check("R1/R2/R3/R4/R5/R6 sweep", er, ev, er[31], er == 32'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule